// File: doc/BRIEF.md
# Two-Table Symmetric Activation Evaluator

This block evaluates a point-symmetric, saturating activation curve for a 12-bit signed fixed-point operand (4 integer bits with the sign in bit 11, 8 fractional bits). It does not store one wide table entry per sample. Instead it rebuilds each sample from two read-only tables. A band table holds the smallest value found in each run of 2^k consecutive samples. An offset table holds, for every sample, a narrow unsigned amount to add to the minimum of that sample's band. Both tables are read in the same cycle. Their contents are computed at elaboration from the block's parameters.

The block first folds a negative operand to its magnitude. It compares the magnitude with an upper threshold. When the magnitude is at or below the threshold, it reads both tables and adds the two results. When the magnitude is above the threshold, the tables stay idle and a saturation constant is used in place of the lookup. A negative operand finally takes the constant minus the positive-side value. The stored curve is 128 + floor(128·m / (m + 512)) for magnitude m in LSBs. This is a sigmoid-shaped curve whose slope never exceeds 1/4 LSB per step, so band offsets fit in 2 bits when bands are 8 samples wide.

The work is split into three register stages: fold and compare, table read, and combine. A valid flag travels with the data.

Top module: `act_twofold_lut`

## Requirements
- R1: After reset is released, and before any accepted operand has passed through, `valid_out` is 0 and `y_out` is 0.
- R2: `valid_out` equals `valid_in` delayed by exactly three rising clock edges, gaps included. Each result belongs to the operand accepted three edges earlier.
- R3: For a non-negative operand x with 0 ≤ x ≤ 1596 (LSB units, bit 11 = 0), `y_out` = 128 + floor(128·x/(x+512)). This includes the boundary x = 1596, which gives 224.
- R4: For a non-negative operand x > 1596 (1597 to 2047), `y_out` = 256, the saturation constant.
- R5: For a negative operand (bit 11 = 1) other than -2048, with magnitude m = -x, `y_out` = 256 minus the value R3 or R4 gives for m.
- R6: The most negative operand, -2048 (0x800), has magnitude 2048, which saturates, so `y_out` = 0.
- R7: The operand 0 gives `y_out` = 128, the midpoint.
- R8: Every valid result lies in the range 0 to 256 inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Marks `x_in` as an operand to evaluate |
| x_in | input | 12 | Two's-complement operand, 4 integer bits including sign, 8 fractional bits |
| valid_out | output | 1 | Marks `y_out` as a result |
| y_out | output | 12 | Activation value, same fixed-point format as the operand |

## Verification
All 4096 operand codes are streamed through the block, with idle cycles inserted at regular intervals. This separates a fault in the band-minimum or offset contents, which shows up at scattered in-range codes, from a fault in the threshold compare, which shows up at the 1596/1597 pair and its negative mirrors. The negative half tells the fold and the symmetry subtract apart from the positive lookup. The codes 0 and 0x800 isolate the midpoint and the overflowing magnitude of the most negative value. The idle gaps tie each result to its own operand and expose any change in pipeline depth.

// File: rtl/act_lut_pkg.sv
package act_lut_pkg;

    // Sigmoid-shaped curve for a non-negative magnitude a (LSB units)
    function automatic int curve_at(int a, int half, int knee);
        return half + (half * a) / (a + knee);
    endfunction

    // Smallest curve value in band b, limited to samples at or below ht
    function automatic int band_floor(int b, int band_log, int ht, int half, int knee);
        int lo;
        int v;
        lo = curve_at(b << band_log, half, knee);
        for (int j = 0; j < (1 << band_log); j++) begin
            if (((b << band_log) + j) <= ht) begin
                v = curve_at((b << band_log) + j, half, knee);
                if (v < lo) lo = v;
            end
        end
        return lo;
    endfunction

    // Unsigned offset of sample a above the floor of its band
    function automatic int band_offset(int a, int band_log, int ht, int half, int knee);
        return curve_at(a, half, knee) - band_floor(a >> band_log, band_log, ht, half, knee);
    endfunction

endpackage

// File: rtl/act_fold_stage.sv
module act_fold_stage #(
    parameter int XW = 12,
    parameter int AW = 11,
    parameter int HT = 1596
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_in,
    input  logic [XW-1:0] x_in,
    output logic          valid_q,
    output logic          neg_q,
    output logic          sat_q,
    output logic [AW-1:0] idx_q
);
    logic [XW-1:0] mag;
    logic          over;

    always_comb begin
        mag  = x_in[XW-1] ? (~x_in + XW'(1)) : x_in;
        over = mag > XW'(HT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            neg_q   <= 1'b0;
            sat_q   <= 1'b0;
            idx_q   <= '0;
        end else begin
            valid_q <= valid_in;
            neg_q   <= x_in[XW-1];
            sat_q   <= over;
            idx_q   <= mag[AW-1:0];
        end
    end
endmodule

// File: rtl/act_tbl_rom.sv
module act_tbl_rom #(
    parameter int DEPTH    = 1597,
    parameter int AW       = 11,
    parameter int DW       = 2,
    parameter bit BASE_TBL = 1'b0,
    parameter int HT       = 1596,
    parameter int BAND_LOG = 3,
    parameter int HALF     = 128,
    parameter int KNEE     = 512
) (
    input  logic          clk,
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] q
);
    logic [DW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        if (BASE_TBL) begin : g_base
            assign mem[i] = DW'(act_lut_pkg::band_floor(i, BAND_LOG, HT, HALF, KNEE));
        end else begin : g_off
            assign mem[i] = DW'(act_lut_pkg::band_offset(i, BAND_LOG, HT, HALF, KNEE));
        end
    end

    always_ff @(posedge clk) begin
        if (en) begin
            if (int'(addr) < DEPTH) q <= mem[addr];
            else                    q <= '0;
        end
    end
endmodule

// File: rtl/act_merge_stage.sv
module act_merge_stage #(
    parameter int XW     = 12,
    parameter int BASE_W = 8,
    parameter int ERR_W  = 2,
    parameter int SAT    = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_d,
    input  logic              neg_d,
    input  logic              sat_d,
    input  logic [BASE_W-1:0] base_d,
    input  logic [ERR_W-1:0]  off_d,
    output logic              valid_out,
    output logic [XW-1:0]     y_out
);
    logic [XW-1:0] rebuilt;
    logic [XW-1:0] pos_side;
    logic [XW-1:0] folded;

    always_comb begin
        rebuilt  = XW'(base_d) + XW'(off_d);
        pos_side = sat_d ? XW'(SAT) : rebuilt;
        folded   = neg_d ? (XW'(SAT) - pos_side) : pos_side;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            y_out     <= '0;
        end else begin
            valid_out <= valid_d;
            if (valid_d) y_out <= folded;
        end
    end
endmodule

// File: rtl/act_twofold_lut.sv
module act_twofold_lut #(
    parameter int XW       = 12,
    parameter int HT       = 1596,
    parameter int BAND_LOG = 3,
    parameter int BASE_W   = 8,
    parameter int ERR_W    = 2,
    parameter int HALF     = 128,
    parameter int KNEE     = 512,
    parameter int SAT      = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_in,
    input  logic [XW-1:0] x_in,
    output logic          valid_out,
    output logic [XW-1:0] y_out
);
    localparam int DEPTH = HT + 1;
    localparam int AW    = $clog2(DEPTH);
    localparam int BANDS = (DEPTH + (1 << BAND_LOG) - 1) >> BAND_LOG;
    localparam int BAW   = AW - BAND_LOG;

    // stage 1: fold and compare
    logic          v1, neg1, sat1;
    logic [AW-1:0] idx1;

    act_fold_stage #(.XW(XW), .AW(AW), .HT(HT)) u_fold (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .x_in(x_in),
        .valid_q(v1), .neg_q(neg1), .sat_q(sat1), .idx_q(idx1)
    );

    // stage 2: parallel table read, tables idle when saturated
    logic              rd_en;
    logic              v2, neg2, sat2;
    logic [BASE_W-1:0] base2;
    logic [ERR_W-1:0]  off2;

    assign rd_en = v1 & ~sat1;

    act_tbl_rom #(
        .DEPTH(BANDS), .AW(BAW), .DW(BASE_W), .BASE_TBL(1'b1),
        .HT(HT), .BAND_LOG(BAND_LOG), .HALF(HALF), .KNEE(KNEE)
    ) u_band_rom (
        .clk(clk), .en(rd_en), .addr(idx1[AW-1:BAND_LOG]), .q(base2)
    );

    act_tbl_rom #(
        .DEPTH(DEPTH), .AW(AW), .DW(ERR_W), .BASE_TBL(1'b0),
        .HT(HT), .BAND_LOG(BAND_LOG), .HALF(HALF), .KNEE(KNEE)
    ) u_off_rom (
        .clk(clk), .en(rd_en), .addr(idx1), .q(off2)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v2   <= 1'b0;
            neg2 <= 1'b0;
            sat2 <= 1'b0;
        end else begin
            v2   <= v1;
            neg2 <= neg1;
            sat2 <= sat1;
        end
    end

    // stage 3: rebuild, saturate, mirror
    act_merge_stage #(.XW(XW), .BASE_W(BASE_W), .ERR_W(ERR_W), .SAT(SAT)) u_merge (
        .clk(clk), .rst_n(rst_n), .valid_d(v2), .neg_d(neg2), .sat_d(sat2),
        .base_d(base2), .off_d(off2), .valid_out(valid_out), .y_out(y_out)
    );
endmodule

// File: rtl/act_twofold_lut_chk.sv
module act_twofold_lut_chk #(
    parameter int XW  = 12,
    parameter int HT  = 1596,
    parameter int SAT = 256
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid_in,
    input logic [XW-1:0] x_in,
    input logic          valid_out,
    input logic [XW-1:0] y_out
);
    logic [1:0] since;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            since <= '0;
        else if (since != 2'd3) since <= since + 2'd1;
    end
    assign warm = (since == 2'd3);

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (valid_out == $past(valid_in, 3)));

    a_r4_pos_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && valid_out && !$past(x_in[XW-1], 3) && ($past(x_in, 3) > XW'(HT)))
        |-> (y_out == XW'(SAT)));

    a_r6_most_negative: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && valid_out && ($past(x_in, 3) == {1'b1, {(XW-1){1'b0}}}))
        |-> (y_out == '0));

    a_r7_zero_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && valid_out && ($past(x_in, 3) == '0))
        |-> (y_out == XW'(SAT / 2)));

    a_r8_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (y_out <= XW'(SAT)));
endmodule

bind act_twofold_lut act_twofold_lut_chk #(.XW(XW), .HT(HT), .SAT(SAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .x_in(x_in),
    .valid_out(valid_out), .y_out(y_out)
);

// File: tb/tb_act_twofold_lut.sv
module tb_act_twofold_lut;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [11:0] x_in = '0;
    logic        valid_out;
    logic [11:0] y_out;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int wr_ptr = 0;
    int rd_ptr = 0;
    bit finished = 1'b0;

    logic [11:0] q_x   [8192];
    int          q_cyc [8192];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    act_twofold_lut dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .x_in(x_in),
        .valid_out(valid_out), .y_out(y_out)
    );

    function automatic int pos_model(int m);
        if (m > 1596) return 256;
        return 128 + (128 * m) / (m + 512);
    endfunction

    function automatic int model(logic [11:0] x);
        int m;
        if (x[11]) begin
            m = 4096 - int'(x);
            return 256 - pos_model(m);
        end
        return pos_model(int'(x));
    endfunction

    function automatic string tag_of(logic [11:0] x);
        if (x == 12'h000) return "R7";
        if (x == 12'h800) return "R6";
        if (x[11])        return "R5";
        if (int'(x) > 1596) return "R4";
        return "R3";
    endfunction

    task automatic check(string req, int act, int expv);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // result monitor: outputs change at posedge, sampled at negedge
    always @(negedge clk) begin
        if (rst_n && valid_out && !finished) begin
            if (rd_ptr >= wr_ptr) begin
                check("R2 unexpected result", 1, 0);
            end else begin
                check("R2 latency", cyc - q_cyc[rd_ptr], 3);
                check(tag_of(q_x[rd_ptr]), int'(y_out), model(q_x[rd_ptr]));
                check("R8 range", int'(y_out <= 12'd256), 1);
                rd_ptr++;
            end
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: idle outputs after reset
        check("R1 valid_out", int'(valid_out), 0);
        check("R1 y_out", int'(y_out), 0);

        for (int i = 0; i < 4096; i++) begin
            @(negedge clk);
            valid_in = 1'b1;
            x_in = 12'(i);
            q_x[wr_ptr] = 12'(i);
            q_cyc[wr_ptr] = cyc;
            wr_ptr++;
            if ((i % 7) == 6) begin
                @(negedge clk);
                valid_in = 1'b0;
                x_in = 12'hABC;
            end
        end
        // explicit boundary operands once more, with idle gaps
        foreach (q_x[k]) begin
            if (k >= 6) break;
            @(negedge clk);
            valid_in = 1'b1;
            case (k)
                0: x_in = 12'd1596;
                1: x_in = 12'd1597;
                2: x_in = 12'h800;
                3: x_in = 12'h000;
                4: x_in = 12'(4096 - 1596);
                default: x_in = 12'(4096 - 1597);
            endcase
            q_x[wr_ptr] = x_in;
            q_cyc[wr_ptr] = cyc;
            wr_ptr++;
            @(negedge clk);
            valid_in = 1'b0;
        end
        repeat (6) @(negedge clk);
        // R2: every accepted operand produced exactly one result
        check("R2 result count", rd_ptr, wr_ptr);
        // R2: no result while idle
        check("R2 idle valid_out", int'(valid_out), 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule